// File: doc/BRIEF.md
# Message Queue Pointer Interrupt Monitor

This block holds the head and tail pointers of four in-memory message queues: a CPU message queue, a device message queue, a resumable error queue and a non-resumable error queue. Software reaches each pointer through a single-cycle address/data access port. Any pointer may be written or read at any time. The block never touches the queue memory and never wraps or moves a pointer by itself.

For the CPU message, device message and resumable error queues, the block holds a level interrupt request high whenever that queue's stored head differs from its stored tail. The request drops when software makes the two equal again. The non-resumable error pointers are stored and can be read back, but they have no interrupt output. Accesses are plain strobes with no back-pressure. The access port is control traffic, so it has no valid/ready handshake: one access is taken on every clock where `acc_en` is high.

Top module: `qptr_irq_monitor`

## Requirements
- R1: After reset every pointer reads as zero, all three interrupt requests are low, and `acc_rvalid` and `acc_err` are low.
- R2: Address bits [2:1] select the queue (0 CPU message, 1 device message, 2 resumable error, 3 non-resumable error), and bit 0 selects head (0) or tail (1). A write with `acc_en` and `acc_wr` high stores the full 64-bit `acc_wdata` into that pointer only.
- R3: A read (`acc_en` high, `acc_wr` low) raises `acc_rvalid` and presents the stored pointer on `acc_rdata` in the next cycle. A read changes no pointer and no interrupt.
- R4: `irq_req[0]` (CPU message), `irq_req[1]` (device message) and `irq_req[2]` (resumable error) are high exactly when their queue's head differs from its tail. The new level is visible in the cycle after the write that changes it.
- R5: Writes to the non-resumable error pointers are stored and readable, but never change any interrupt request.
- R6: Writing a pointer so that head equals tail again drops that queue's request in the next cycle.
- R7: An access with any address bit above bit 2 set is unmapped. It changes no pointer. A read of such an address returns zero. `acc_err` is high in the next cycle for that access only.
- R8: A write to one queue never changes another queue's interrupt request.
- R9: The head/tail comparison covers all 64 bits, so pointers that differ only in bit 63 raise the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe, one access per cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_addr | input | ADDR_W (4) | Pointer address |
| acc_wdata | input | PTR_W (64) | Write data |
| acc_rdata | output | PTR_W (64) | Read data, valid with acc_rvalid |
| acc_rvalid | output | 1 | Read response, one cycle after the read |
| acc_err | output | 1 | One-cycle pulse for an unmapped access |
| irq_req | output | 3 | Level requests: CPU msg, device msg, resumable error |

## Verification
Head/tail pairs are driven apart and back together in an interleaved order. A design that compared the wrong pair, or that let a write to one queue disturb another, would show a wrong request level on a neighbour. Pointers that differ only in bit 63 catch a comparator that looks at fewer bits. Writes to the non-resumable error pair check that a fourth interrupt has not been wired onto an existing output. An unmapped write whose low bits alias head 0 is followed by a read of head 0, which exposes a decoder that drops the upper address bits. A reset in the middle of the run must clear pointers that hold non-zero data.

// File: rtl/qmon_pkg.sv
package qmon_pkg;
  localparam int NUM_Q     = 4;
  localparam int NUM_IRQ_Q = 3;
  localparam int SLOT_W    = $clog2(NUM_Q * 2);

  typedef enum logic [1:0] {
    Q_CPU_MSG  = 2'd0,
    Q_DEV_MSG  = 2'd1,
    Q_RES_ERR  = 2'd2,
    Q_NRES_ERR = 2'd3
  } qid_e;

  // A queue raises a request only if it sits below the interrupting count.
  function automatic bit queue_interrupts(input int q);
    return q < NUM_IRQ_Q;
  endfunction
endpackage

// File: rtl/qmon_decode.sv
module qmon_decode
  import qmon_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [NUM_Q-1:0]  wr_head,
  output logic [NUM_Q-1:0]  wr_tail,
  output logic              rd_any,
  output logic              unmapped,
  output logic [SLOT_W-1:0] slot
);
  logic mapped;

  assign slot = acc_addr[SLOT_W-1:0];

  generate
    if (ADDR_W > SLOT_W) begin : g_upper
      assign mapped = (acc_addr[ADDR_W-1:SLOT_W] == '0);
    end else begin : g_exact
      assign mapped = 1'b1;
    end
  endgenerate

  assign unmapped = acc_en & ~mapped;
  assign rd_any   = acc_en & ~acc_wr;

  always_comb begin
    for (int q = 0; q < NUM_Q; q++) begin
      wr_head[q] = acc_en & acc_wr & mapped & (slot == SLOT_W'(2 * q));
      wr_tail[q] = acc_en & acc_wr & mapped & (slot == SLOT_W'(2 * q + 1));
    end
  end
endmodule

// File: rtl/qmon_ptr_pair.sv
module qmon_ptr_pair #(
  parameter int PTR_W  = 64,
  parameter bit IRQ_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_head,
  input  logic             wr_tail,
  input  logic [PTR_W-1:0] wdata,
  output logic [PTR_W-1:0] head_q,
  output logic [PTR_W-1:0] tail_q,
  output logic             irq
);
  logic [PTR_W-1:0] head_d, tail_d;

  assign head_d = wr_head ? wdata : head_q;
  assign tail_d = wr_tail ? wdata : tail_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
    end
  end

  generate
    if (IRQ_EN) begin : g_irq
      logic irq_q;
      always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= (head_d != tail_d);
      end
      assign irq = irq_q;
    end else begin : g_no_irq
      assign irq = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/qmon_rd_mux.sv
module qmon_rd_mux
  import qmon_pkg::*;
#(
  parameter int PTR_W = 64
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        rd_any,
  input  logic                        unmapped,
  input  logic [SLOT_W-1:0]           slot,
  input  logic [NUM_Q-1:0][PTR_W-1:0] head_all,
  input  logic [NUM_Q-1:0][PTR_W-1:0] tail_all,
  output logic [PTR_W-1:0]            rdata,
  output logic                        rvalid,
  output logic                        err
);
  logic [PTR_W-1:0] sel;

  always_comb begin
    sel = '0;
    for (int q = 0; q < NUM_Q; q++) begin
      if (slot == SLOT_W'(2 * q))     sel = head_all[q];
      if (slot == SLOT_W'(2 * q + 1)) sel = tail_all[q];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata  <= '0;
      rvalid <= 1'b0;
      err    <= 1'b0;
    end else begin
      rvalid <= rd_any;
      err    <= unmapped;
      if (rd_any) rdata <= unmapped ? '0 : sel;
    end
  end
endmodule

// File: rtl/qptr_irq_monitor.sv
module qptr_irq_monitor
  import qmon_pkg::*;
#(
  parameter int PTR_W  = 64,
  parameter int ADDR_W = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 acc_en,
  input  logic                 acc_wr,
  input  logic [ADDR_W-1:0]    acc_addr,
  input  logic [PTR_W-1:0]     acc_wdata,
  output logic [PTR_W-1:0]     acc_rdata,
  output logic                 acc_rvalid,
  output logic                 acc_err,
  output logic [NUM_IRQ_Q-1:0] irq_req
);
  logic [NUM_Q-1:0]            wr_head, wr_tail;
  logic                        rd_any, unmapped;
  logic [SLOT_W-1:0]           slot;
  logic [NUM_Q-1:0][PTR_W-1:0] head_all, tail_all;
  logic [NUM_Q-1:0]            irq_all;

  qmon_decode #(.ADDR_W(ADDR_W)) u_dec (
    .acc_en   (acc_en),
    .acc_wr   (acc_wr),
    .acc_addr (acc_addr),
    .wr_head  (wr_head),
    .wr_tail  (wr_tail),
    .rd_any   (rd_any),
    .unmapped (unmapped),
    .slot     (slot)
  );

  generate
    for (genvar q = 0; q < NUM_Q; q++) begin : g_pair
      qmon_ptr_pair #(
        .PTR_W  (PTR_W),
        .IRQ_EN (queue_interrupts(q))
      ) u_pair (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_head (wr_head[q]),
        .wr_tail (wr_tail[q]),
        .wdata   (acc_wdata),
        .head_q  (head_all[q]),
        .tail_q  (tail_all[q]),
        .irq     (irq_all[q])
      );
    end
  endgenerate

  assign irq_req = irq_all[NUM_IRQ_Q-1:0];

  qmon_rd_mux #(.PTR_W(PTR_W)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_any   (rd_any),
    .unmapped (unmapped),
    .slot     (slot),
    .head_all (head_all),
    .tail_all (tail_all),
    .rdata    (acc_rdata),
    .rvalid   (acc_rvalid),
    .err      (acc_err)
  );
endmodule

// File: rtl/qmon_checker.sv
module qmon_checker
  import qmon_pkg::*;
#(
  parameter int PTR_W  = 64,
  parameter int ADDR_W = 4
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        acc_en,
  input logic                        acc_wr,
  input logic [ADDR_W-1:0]           acc_addr,
  input logic                        acc_rvalid,
  input logic                        acc_err,
  input logic [NUM_IRQ_Q-1:0]        irq_req,
  input logic [NUM_Q-1:0][PTR_W-1:0] head_all,
  input logic [NUM_Q-1:0][PTR_W-1:0] tail_all
);
  logic is_unmapped;
  assign is_unmapped = (acc_addr >> SLOT_W) != '0;

  generate
    for (genvar i = 0; i < NUM_IRQ_Q; i++) begin : g_irq_chk
      a_r4_irq_tracks_pair: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req[i] == (head_all[i] != tail_all[i]));
    end
  endgenerate

  a_r7_err_follows_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && is_unmapped) |=> acc_err);

  a_r7_err_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> $past(acc_en && is_unmapped));

  a_r7_unmapped_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && is_unmapped) |=> $stable(irq_req));

  a_r3_rvalid_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    acc_rvalid |-> $past(acc_en && !acc_wr));

  a_r3_read_keeps_irq: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && !acc_wr) |=> $stable(irq_req));

  a_r5_nres_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && !is_unmapped && acc_addr[2:1] == 2'd3) |=> $stable(irq_req));
endmodule

bind qptr_irq_monitor qmon_checker #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_qptr_irq_monitor.sv
`timescale 1ns/1ps
module sim_qptr_irq_monitor;
  localparam int PTR_W  = 64;
  localparam int ADDR_W = 4;
  localparam logic [63:0] MSB = 64'h8000_0000_0000_0000;

  typedef struct packed {
    logic        wr;
    logic [3:0]  addr;
    logic [63:0] data;
    logic [2:0]  irq;
    logic        err;
  } vec_t;

  // Read vectors carry the expected read data in the data field.
  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 4'd0, 64'd5,  3'b001, 1'b0},  // R2 R4 head cpu
    '{1'b0, 4'd0, 64'd5,  3'b001, 1'b0},  // R3 readback
    '{1'b1, 4'd1, 64'd5,  3'b000, 1'b0},  // R6 tail equal
    '{1'b1, 4'd2, MSB,    3'b010, 1'b0},  // R9 bit 63 only
    '{1'b1, 4'd5, 64'd7,  3'b110, 1'b0},  // R8 res tail
    '{1'b1, 4'd6, 64'd9,  3'b110, 1'b0},  // R5 nres head
    '{1'b0, 4'd6, 64'd9,  3'b110, 1'b0},  // R5 readable
    '{1'b0, 4'd7, 64'd0,  3'b110, 1'b0},  // R3
    '{1'b1, 4'd3, MSB,    3'b100, 1'b0},  // R6 dev equal
    '{1'b1, 4'd4, 64'd7,  3'b000, 1'b0},  // R6 res equal
    '{1'b1, 4'd8, 64'hFF, 3'b000, 1'b1},  // R7 unmapped write
    '{1'b0, 4'd9, 64'd0,  3'b000, 1'b1},  // R7 unmapped read
    '{1'b1, 4'd7, 64'd1,  3'b000, 1'b0},  // R5 nres tail
    '{1'b0, 4'd3, MSB,    3'b000, 1'b0}   // R2 R9
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              acc_en, acc_wr;
  logic [ADDR_W-1:0] acc_addr;
  logic [PTR_W-1:0]  acc_wdata, acc_rdata;
  logic              acc_rvalid, acc_err;
  logic [2:0]        irq_req;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  qptr_irq_monitor #(.PTR_W(PTR_W), .ADDR_W(ADDR_W)) u0 (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Drive one access for one cycle; return sampled at the following negedge.
  task automatic access(input logic wr, input logic [3:0] addr, input logic [63:0] data);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = wr; acc_addr = addr; acc_wdata = data;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    rst_n = 1'b0; acc_en = 1'b0; acc_wr = 1'b0; acc_addr = '0; acc_wdata = '0;
    do_reset();
    // R1: reset state
    check("R1 irq", 64'(irq_req), 64'd0);
    check("R1 rvalid", 64'(acc_rvalid), 64'd0);
    check("R1 err", 64'(acc_err), 64'd0);
    for (int a = 0; a < 8; a++) begin
      access(1'b0, 4'(a), 64'd0);
      check("R1 ptr zero", acc_rdata, 64'd0);
    end

    for (int i = 0; i < NV; i++) begin
      access(VEC[i].wr, VEC[i].addr, VEC[i].data);
      check("R4 R8 irq level", 64'(irq_req), 64'(VEC[i].irq));
      check("R7 err", 64'(acc_err), 64'(VEC[i].err));
      check("R3 rvalid", 64'(acc_rvalid), 64'(!VEC[i].wr));
      if (!VEC[i].wr) check("R3 R7 rdata", acc_rdata, VEC[i].data);
    end

    // R7: the unmapped write at 8 must not alias head of queue 0
    access(1'b0, 4'd0, 64'd0);
    check("R7 no alias", acc_rdata, 64'd5);
    // err lasts one cycle only
    access(1'b1, 4'd12, 64'd3);
    @(negedge clk);
    check("R7 err one cycle", 64'(acc_err), 64'd0);

    // R4: the request appears in the cycle after the write, not before
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_addr = 4'd1; acc_wdata = 64'd6;
    check("R4 before edge", 64'(irq_req), 64'd0);
    @(negedge clk);
    acc_en = 1'b0;
    check("R4 after edge", 64'(irq_req), 64'd1);

    // R1: reset mid-run clears non-zero pointers
    do_reset();
    check("R1 irq after reset", 64'(irq_req), 64'd0);
    access(1'b0, 4'd6, 64'd0);
    check("R1 nres head cleared", acc_rdata, 64'd0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule